// File: doc/BRIEF.md
# Read Address Pointer with Wrapped Bursts and Relative Jumps

This block holds the byte address for a serial flash read path. A read command loads a start address and chooses one of two patterns. In the linear pattern the pointer walks through the whole address space and rolls over from the top to zero. In the wrapped pattern it stays inside an aligned window of 8, 16, 32 or 64 bytes. The window size comes from a small length register that keeps its value across commands.

A relative jump moves the pointer by a signed offset. The offset can count bytes within the current 256-byte page, bytes within the current 64 KB block, or whole 64 KB blocks. The starting point of a jump depends on the pattern in force. In the wrapped pattern it is the address most recently supplied as a target, meaning a load or a previous jump. In the linear pattern it is the byte most recently completed. A jump does not change the pattern that was in force, so later advances keep the wrapping of the last ordinary read.

The serial front end pulses an advance strobe once per completed byte. The data array reads the pointer directly.

Top module: `rd_addr_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the pointer becomes 0, the pattern becomes linear and the window length code becomes 0 (8 bytes).
- R2: When `load_i` is high, the pointer equals `load_addr_i` after the edge, and the pattern (`load_mode_i`: 0 linear, 1 wrapped) is stored.
- R3: In the linear pattern, each `adv_i` pulse adds one to the pointer, and the pointer rolls from all ones to 0.
- R4: In the wrapped pattern, each `adv_i` pulse adds one to the low bits inside the window and leaves the bits above the window unchanged. For example, start 06h with length 8 gives 06h, 07h, 00h, 01h.
- R5: A pulse on `set_len_i` stores `len_code_i`. Codes 0, 1, 2 and 3 select windows of 8, 16, 32 and 64 bytes. The length is 8 until a code is set.
- R6: Jump kind 0 (page) adds sign-extended `jump_off_i[7:0]` to the low 8 bits of the base and leaves the upper bits unchanged, so the result wraps within the 256-byte page in both directions.
- R7: Jump kind 1 (index) adds `jump_off_i[15:0]` to the low 16 bits of the base and leaves the upper bits unchanged, so the result wraps within the 64 KB block.
- R8: Jump kind 2 (block) adds sign-extended `jump_off_i[7:0]` to the address bits above bit 15, modulo the address space, and keeps the low 16 bits of the base.
- R9: In the wrapped pattern the jump base is the last load or jump target. In the linear pattern it is the address of the last byte completed by `adv_i`, or the last target if no byte has completed since that target.
- R10: A jump leaves the stored pattern and window length unchanged, so advances after a jump wrap as the last ordinary read did.
- R11: Without a strobe the pointer holds. `load_i` overrides `jump_i`, and `jump_i` overrides `adv_i`. Jump kind 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start an ordinary read at `load_addr_i` |
| load_addr_i | input | ADDR_W | Start address |
| load_mode_i | input | 1 | Pattern for the read: 0 linear, 1 wrapped |
| set_len_i | input | 1 | Store a new window length code |
| len_code_i | input | 2 | Window length code |
| jump_i | input | 1 | Apply a relative jump |
| jump_kind_i | input | 2 | 0 page, 1 index, 2 block, 3 none |
| jump_off_i | input | 16 | Signed jump offset |
| adv_i | input | 1 | One byte completed |
| addr_o | output | ADDR_W | Current byte address |

## Verification
The hardest case to reach is a jump taken during a linear read after several bytes have completed. There the base is the last completed byte and not the pointer, so the two differ by one, and the offset also has to cross a page or block edge. The stimulus loads an address, advances it a few times, and then issues a backward page jump that underflows. Directed checks also jump into the top of a wrapped window and advance past its end. A long pseudo-random run mixes loads, length changes, all four jump kinds and advances in the same cycle, and compares the output on every clock against an integer model.

// File: rtl/rag_pkg.sv
package rag_pkg;

    typedef enum logic {
        RD_LINEAR = 1'b0,
        RD_WRAP   = 1'b1
    } rd_kind_e;

    typedef enum logic [1:0] {
        JMP_PAGE  = 2'd0,
        JMP_INDEX = 2'd1,
        JMP_BLOCK = 2'd2,
        JMP_NONE  = 2'd3
    } jmp_kind_e;

    localparam int LEN_CODE_W = 2;
    localparam int PAGE_W     = 8;
    localparam int BLK_W      = 16;
    localparam int OFF_W      = 16;
    localparam int MIN_WIN_LG = 3;
    localparam int MAX_WIN_LG = MIN_WIN_LG + (1 << LEN_CODE_W) - 1;

    typedef struct packed {
        rd_kind_e                kind;
        logic [LEN_CODE_W-1:0]   len_code;
    } rd_cfg_t;

    function automatic logic [MAX_WIN_LG-1:0] win_mask(input logic [LEN_CODE_W-1:0] code);
        return MAX_WIN_LG'((1 << (MIN_WIN_LG + int'(code))) - 1);
    endfunction

endpackage

// File: rtl/rag_len_reg.sv
module rag_len_reg
    import rag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_i,
    input  logic [LEN_CODE_W-1:0] code_i,
    output logic [LEN_CODE_W-1:0] code_o
);

    logic [LEN_CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (set_i)
            code_q <= code_i;
    end

    assign code_o = code_q;

    assert_len_set_R5: assert property (@(posedge clk) disable iff (rst)
        set_i |=> code_o == $past(code_i));

    assert_len_keep_R5: assert property (@(posedge clk) disable iff (rst)
        !set_i |=> $stable(code_o));

endmodule

// File: rtl/rag_step.sv
module rag_step
    import rag_pkg::*;
#(
    parameter int ADDR_W = 24
)(
    input  logic [ADDR_W-1:0]     addr_i,
    input  rd_kind_e              kind_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    output logic [ADDR_W-1:0]     next_o
);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;

    always_comb begin
        mask = ADDR_W'(win_mask(len_code_i));
        inc  = addr_i + 1'b1;
        if (kind_i == RD_WRAP)
            next_o = (addr_i & ~mask) | (inc & mask);
        else
            next_o = inc;
    end

endmodule

// File: rtl/rag_jump_calc.sv
module rag_jump_calc
    import rag_pkg::*;
#(
    parameter int ADDR_W = 24
)(
    input  logic [ADDR_W-1:0] base_i,
    input  jmp_kind_e         kind_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int UP_W = ADDR_W - BLK_W;

    logic [PAGE_W-1:0] page_low;
    logic [BLK_W-1:0]  blk_low;
    logic [UP_W-1:0]   blk_up;
    logic [UP_W-1:0]   blk_delta;

    always_comb begin
        blk_delta = UP_W'($signed(off_i[PAGE_W-1:0]));
        page_low  = base_i[PAGE_W-1:0] + off_i[PAGE_W-1:0];
        blk_low   = base_i[BLK_W-1:0] + off_i;
        blk_up    = base_i[ADDR_W-1:BLK_W] + blk_delta;
        unique case (kind_i)
            JMP_PAGE:  target_o = {base_i[ADDR_W-1:PAGE_W], page_low};
            JMP_INDEX: target_o = {base_i[ADDR_W-1:BLK_W], blk_low};
            JMP_BLOCK: target_o = {blk_up, base_i[BLK_W-1:0]};
            default:   target_o = base_i;
        endcase
    end

endmodule

// File: rtl/rd_addr_gen.sv
module rd_addr_gen
    import rag_pkg::*;
#(
    parameter int ADDR_W = 24
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              load_mode_i,
    input  logic              set_len_i,
    input  logic [1:0]        len_code_i,
    input  logic              jump_i,
    input  logic [1:0]        jump_kind_i,
    input  logic [15:0]       jump_off_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0]     addr_q;
    logic [ADDR_W-1:0]     anchor_q;
    logic [ADDR_W-1:0]     last_q;
    rd_kind_e              mode_q;
    logic [LEN_CODE_W-1:0] len_code;
    logic [ADDR_W-1:0]     base_w;
    logic [ADDR_W-1:0]     target_w;
    logic [ADDR_W-1:0]     step_w;
    jmp_kind_e             jkind;
    logic                  jump_live;

    assign jkind     = jmp_kind_e'(jump_kind_i);
    assign jump_live = jump_i && (jkind != JMP_NONE);
    assign base_w    = (mode_q == RD_WRAP) ? anchor_q : last_q;

    rag_len_reg u_len (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_len_i),
        .code_i (len_code_i),
        .code_o (len_code)
    );

    rag_jump_calc #(.ADDR_W(ADDR_W)) u_jump (
        .base_i   (base_w),
        .kind_i   (jkind),
        .off_i    (jump_off_i),
        .target_o (target_w)
    );

    rag_step #(.ADDR_W(ADDR_W)) u_step (
        .addr_i     (addr_q),
        .kind_i     (mode_q),
        .len_code_i (len_code),
        .next_o     (step_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            anchor_q <= '0;
            last_q   <= '0;
            mode_q   <= RD_LINEAR;
        end else if (load_i) begin
            addr_q   <= load_addr_i;
            anchor_q <= load_addr_i;
            last_q   <= load_addr_i;
            mode_q   <= rd_kind_e'(load_mode_i);
        end else if (jump_i) begin
            if (jump_live) begin
                addr_q   <= target_w;
                anchor_q <= target_w;
                last_q   <= target_w;
            end
        end else if (adv_i) begin
            last_q <= addr_q;
            addr_q <= step_w;
        end
    end

    assign addr_o = addr_q;

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> addr_o == $past(load_addr_i));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !jump_i && !adv_i) |=> $stable(addr_o));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !jump_i && adv_i && mode_q == RD_LINEAR)
        |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !jump_i && adv_i && mode_q == RD_WRAP)
        |=> (addr_o >> MAX_WIN_LG) == $past(addr_o >> MAX_WIN_LG));

    assert_page_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && jump_i && jkind == JMP_PAGE)
        |=> addr_o[ADDR_W-1:PAGE_W] == $past(base_w[ADDR_W-1:PAGE_W]));

    assert_block_low_R8: assert property (@(posedge clk) disable iff (rst)
        (!load_i && jump_i && jkind == JMP_BLOCK)
        |=> addr_o[BLK_W-1:0] == $past(base_w[BLK_W-1:0]));

    assert_wrap_base_R9: assert property (@(posedge clk) disable iff (rst)
        (!load_i && jump_i && jkind == JMP_INDEX && mode_q == RD_WRAP)
        |=> addr_o[ADDR_W-1:BLK_W] == $past(anchor_q[ADDR_W-1:BLK_W]));

    assert_mode_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (!load_i && jump_i) |=> $stable(mode_q));

    assert_none_R11: assert property (@(posedge clk) disable iff (rst)
        (!load_i && jump_i && jkind == JMP_NONE) |=> $stable(addr_o));

endmodule

// File: tb/rd_addr_gen_tb_top.sv
module rd_addr_gen_tb_top;

    localparam int AW   = 24;
    localparam int SIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          load_mode_i = 1'b0;
    logic          set_len_i = 1'b0;
    logic [1:0]    len_code_i = '0;
    logic          jump_i = 1'b0;
    logic [1:0]    jump_kind_i = '0;
    logic [15:0]   jump_off_i = '0;
    logic          adv_i = 1'b0;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_addr = 0, m_anchor = 0, m_last = 0, m_mode = 0, m_code = 0;

    always #4 clk = ~clk;

    rd_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
        .load_mode_i(load_mode_i), .set_len_i(set_len_i), .len_code_i(len_code_i),
        .jump_i(jump_i), .jump_kind_i(jump_kind_i), .jump_off_i(jump_off_i),
        .adv_i(adv_i), .addr_o(addr_o)
    );

    function automatic int pmod(int x, int m);
        int r = x % m;
        return (r < 0) ? r + m : r;
    endfunction

    function automatic int sx8(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic int sx16(int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_anchor = 0; m_last = 0; m_mode = 0; m_code = 0;
        end else begin
            if (load_i) begin
                m_addr = int'(load_addr_i);
                m_anchor = m_addr; m_last = m_addr; m_mode = int'(load_mode_i);
            end else if (jump_i) begin
                int b, t, off;
                b = (m_mode == 1) ? m_anchor : m_last;
                off = int'(jump_off_i);
                t = b;
                case (jump_kind_i)
                    2'd0: t = (b / 256) * 256 + pmod(b % 256 + sx8(off % 256), 256);
                    2'd1: t = (b / 65536) * 65536 + pmod(b % 65536 + sx16(off), 65536);
                    2'd2: t = pmod(b / 65536 + sx8(off % 256), SIZE / 65536) * 65536 + b % 65536;
                    default: t = b;
                endcase
                if (jump_kind_i != 2'd3) begin
                    m_addr = t; m_anchor = t; m_last = t;
                end
            end else if (adv_i) begin
                m_last = m_addr;
                if (m_mode == 1) begin
                    int len;
                    len = 8 << m_code;
                    m_addr = m_addr - (m_addr % len) + ((m_addr % len) + 1) % len;
                end else begin
                    m_addr = (m_addr + 1) % SIZE;
                end
            end
            if (set_len_i) m_code = int'(len_code_i);
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (int'(addr_o) != m_addr) begin
                errors++;
                $display("FAIL %s model compare: actual %06h expected %06h", cur_req, addr_o, m_addr);
            end
        end
    end

    task automatic chk(input int exp, input string req);
        checks++;
        if (int'(addr_o) != exp) begin
            errors++;
            $display("FAIL %s directed: actual %06h expected %06h", req, addr_o, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        load_i = 0; set_len_i = 0; jump_i = 0; adv_i = 0;
    endtask

    task automatic do_load(input int a, input bit wrap);
        load_i = 1; load_addr_i = AW'(a); load_mode_i = wrap; tick();
    endtask

    task automatic do_adv();
        adv_i = 1; tick();
    endtask

    task automatic do_jump(input int kind, input int off);
        jump_i = 1; jump_kind_i = 2'(kind); jump_off_i = 16'(off); tick();
    endtask

    task automatic do_len(input int code);
        set_len_i = 1; len_code_i = 2'(code); tick();
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(0, "R1");
        tick(); chk(0, "R11");

        cur_req = "R4";
        do_load(32'h000006, 1); chk(32'h06, "R2");
        do_adv(); chk(32'h07, "R4");
        do_adv(); chk(32'h00, "R4");
        do_adv(); chk(32'h01, "R5");

        cur_req = "R5";
        do_len(1);
        do_load(32'h00001E, 1);
        do_adv(); chk(32'h1F, "R5");
        do_adv(); chk(32'h10, "R5");

        cur_req = "R10";
        do_len(3);
        do_load(32'h00001E, 1);
        do_adv(); do_adv(); do_adv(); chk(32'h21, "R4");
        do_jump(0, 32'h20); chk(32'h3E, "R9");
        do_adv(); chk(32'h3F, "R10");
        do_adv(); chk(32'h00, "R10");
        do_jump(0, 32'h40); chk(32'h7E, "R9");

        cur_req = "R9";
        do_load(32'h000010, 0);
        do_adv(); do_adv(); chk(32'h12, "R3");
        do_jump(0, 32'h81); chk(32'h92, "R9");
        do_adv(); chk(32'h93, "R10");

        cur_req = "R6";
        do_load(32'h0000F0, 0);
        do_jump(0, 32'h20); chk(32'h10, "R6");

        cur_req = "R7";
        do_load(32'h120050, 0);
        do_jump(1, 32'hFF00); chk(32'h12FF50, "R7");
        do_load(32'h12FFF0, 0);
        do_jump(1, 32'h0020); chk(32'h120010, "R7");

        cur_req = "R8";
        do_load(32'h003456, 0);
        do_jump(2, 32'h00FF); chk(32'hFF3456, "R8");
        do_jump(2, 32'h0002); chk(32'h013456, "R8");

        cur_req = "R3";
        do_load(32'hFFFFFE, 0);
        do_adv(); chk(32'hFFFFFF, "R3");
        do_adv(); chk(32'h000000, "R3");

        cur_req = "R11";
        do_load(32'h000777, 0);
        do_jump(3, 32'h0010); chk(32'h777, "R11");
        jump_i = 1; jump_kind_i = 2'd3; adv_i = 1; tick(); chk(32'h777, "R11");
        load_i = 1; load_addr_i = 24'h000500; load_mode_i = 0; adv_i = 1; jump_i = 1;
        jump_kind_i = 2'd0; jump_off_i = 16'h0011; tick(); chk(32'h500, "R11");
        jump_i = 1; jump_kind_i = 2'd1; jump_off_i = 16'h0004; adv_i = 1; tick();
        chk(32'h504, "R11");

        cur_req = "R1";
        rst = 1; tick(); rst = 0; chk(0, "R1");

        cur_req = "R9";
        begin
            logic [31:0] lfsr;
            lfsr = 32'hACE1_2345;
            for (int i = 0; i < 4000; i++) begin
                int sel;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                sel = int'(lfsr[3:0]);
                load_i    = (sel == 0);
                load_addr_i = AW'(lfsr[31:8]);
                load_mode_i = lfsr[5];
                set_len_i = (sel == 1) || (sel == 2 && lfsr[9]);
                len_code_i = lfsr[7:6];
                jump_i    = (sel >= 2 && sel <= 4);
                jump_kind_i = lfsr[11:10];
                jump_off_i  = lfsr[27:12];
                adv_i     = (sel >= 3) && (sel != 15);
                tick();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule